// File: doc/BRIEF.md
# Backlight Pulse-Width Modulator with Committed Configuration

This block drives one pulse-width modulated line that sets display backlight brightness. Software programs it through a small single-cycle register port. The port has a select, a write flag, a byte address and 32-bit data. Read data is combinational and is valid in the same cycle as a selected address.

The timing settings are a prescaler, a period count and a high-time count. Each uses N+1 encoding. Software writes them into shadow words that the waveform generator does not use. A 0-to-1 transition of a commit bit copies the shadow values into the active set. While the modulator is running, that copy waits for the end of the current period, so a running cycle is never cut short. An enable bit starts and stops the output. Stopping holds the line low and rewinds both counters.

Top module: `bl_pwm_ctrl`

## Requirements
- R1: After reset, every mapped register reads zero and `pwm_out` is low.
- R2: The four mapped words keep all 32 bits as written and read them back unchanged. These are enable at 0x00, commit at 0x08, prescale at 0x10 and shape at 0x14.
- R3: Any other address reads zero. Writes to it change no mapped word and no output.
- R4: Shadow prescale and shape values have no effect on `pwm_out` until bit 0 of the word at 0x08 goes from 0 to 1. Writing 1 while that bit is already 1 transfers nothing.
- R5: One output period lasts (D+1)×(P+1) clock cycles. D is bits [25:16] of the word at 0x10, and P is bits [11:0] of the word at 0x14.
- R6: Each period starts with `pwm_out` high for (D+1)×(H+1) cycles and then drives it low, where H is bits [28:16] of the word at 0x14.
- R7: When H is greater than or equal to P, `pwm_out` stays high for the whole period.
- R8: A commit made while the modulator runs takes effect at the next period boundary. A commit made while it is stopped takes effect at once.
- R9: Bit 0 of the word at 0x00 enables the modulator. While it is 0, `pwm_out` is low and both counters sit at zero. Setting it to 1 starts a fresh period with the high phase first, in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | Access is a write (1) or a read (0) |
| bus_addr | input | 8 | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected address, zero when not selected |
| pwm_out | output | 1 | Modulated backlight output |

## Verification
The assertions assume that reset is applied before the first access. They also assume that `bus_sel`, `bus_wr`, `bus_addr` and `bus_wdata` are stable around each rising edge, and that each access lasts exactly one cycle. The bench meets this by changing the register inputs only shortly after a falling edge and by returning `bus_sel` to 0 after every access. The bench puts no limits on the programmed values. It uses counts where H is below, equal to and above P, it commits both while running and while stopped, and it repeats a commit write while the commit bit is already set.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  localparam int NUM_WORDS = 4;
  localparam int IDX_RUN   = 0;
  localparam int IDX_LATCH = 1;
  localparam int IDX_SCALE = 2;
  localparam int IDX_SHAPE = 3;

  // bit positions that the register port decodes into the core
  localparam int DIV_LSB = 16;
  localparam int PER_LSB = 0;
  localparam int HW_LSB  = 16;

  function automatic logic [7:0] word_offset(input int idx);
    case (idx)
      IDX_RUN:   return 8'h00;
      IDX_LATCH: return 8'h08;
      IDX_SCALE: return 8'h10;
      default:   return 8'h14;
    endcase
  endfunction
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
  import bl_pwm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 10,
  parameter int PER_W  = 12,
  parameter int HW_W   = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              run_en,
  output logic              commit_stb,
  output logic [DIV_W-1:0]  sh_div,
  output logic [PER_W-1:0]  sh_per,
  output logic [HW_W-1:0]   sh_hw
);
  localparam int FLAT_W = NUM_WORDS * DATA_W;

  logic [FLAT_W-1:0]    word_flat;
  logic [NUM_WORDS-1:0] hit;

  for (genvar gi = 0; gi < NUM_WORDS; gi++) begin : g_word
    logic [DATA_W-1:0] q;
    assign hit[gi] = bus_sel && (bus_addr == ADDR_W'(word_offset(gi)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                q <= '0;
      else if (hit[gi] && bus_wr) q <= bus_wdata;
    end
    assign word_flat[gi*DATA_W +: DATA_W] = q;
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_WORDS; i++)
      if (hit[i]) bus_rdata = word_flat[i*DATA_W +: DATA_W];
  end

  logic [DATA_W-1:0] run_w, latch_w, scale_w, shape_w;
  assign run_w   = word_flat[IDX_RUN*DATA_W   +: DATA_W];
  assign latch_w = word_flat[IDX_LATCH*DATA_W +: DATA_W];
  assign scale_w = word_flat[IDX_SCALE*DATA_W +: DATA_W];
  assign shape_w = word_flat[IDX_SHAPE*DATA_W +: DATA_W];

  assign run_en     = run_w[0];
  assign commit_stb = hit[IDX_LATCH] && bus_wr && bus_wdata[0] && !latch_w[0];
  assign sh_div     = scale_w[DIV_LSB +: DIV_W];
  assign sh_per     = shape_w[PER_LSB +: PER_W];
  assign sh_hw      = shape_w[HW_LSB  +: HW_W];

  p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !(|hit)) |-> (bus_rdata == '0));

  p_hold_words_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && (|hit)) |=> $stable(word_flat));

  p_commit_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_stb |=> !commit_stb);
endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core #(
  parameter int DIV_W = 10,
  parameter int PER_W = 12,
  parameter int HW_W  = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             commit_stb,
  input  logic [DIV_W-1:0] sh_div,
  input  logic [PER_W-1:0] sh_per,
  input  logic [HW_W-1:0]  sh_hw,
  output logic             pwm_out
);
  localparam int CMP_W = (PER_W > HW_W) ? PER_W : HW_W;

  logic [DIV_W-1:0] act_div, pre_q;
  logic [PER_W-1:0] act_per, per_q;
  logic [HW_W-1:0]  act_hw;
  logic             pend_q;
  logic             tick, wrap, want, load;

  assign tick = (pre_q == act_div);
  assign wrap = tick && (per_q == act_per);
  assign want = commit_stb || pend_q;
  assign load = want && (!run_en || wrap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_div <= '0;
      act_per <= '0;
      act_hw  <= '0;
      pend_q  <= 1'b0;
    end else begin
      pend_q <= want && !load;
      if (load) begin
        act_div <= sh_div;
        act_per <= sh_per;
        act_hw  <= sh_hw;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      per_q <= '0;
    end else if (!run_en) begin
      pre_q <= '0;
      per_q <= '0;
    end else if (tick) begin
      pre_q <= '0;
      per_q <= wrap ? '0 : per_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  logic [CMP_W-1:0] per_ext, hw_ext;
  assign per_ext = CMP_W'(per_q);
  assign hw_ext  = CMP_W'(act_hw);
  assign pwm_out = run_en && (per_ext <= hw_ext);

  p_pre_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= act_div);

  p_per_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    per_q <= act_per);

  p_stop_rewind_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (pre_q == '0 && per_q == '0));

  p_no_midcycle_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !wrap) |=> $stable({act_div, act_per, act_hw}));

  p_full_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && CMP_W'(act_hw) >= CMP_W'(act_per)) |-> pwm_out);
endmodule

// File: rtl/bl_pwm_ctrl.sv
module bl_pwm_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 10,
  parameter int PER_W  = 12,
  parameter int HW_W   = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pwm_out
);
  logic             run_en, commit_stb;
  logic [DIV_W-1:0] sh_div;
  logic [PER_W-1:0] sh_per;
  logic [HW_W-1:0]  sh_hw;

  bl_pwm_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .DIV_W(DIV_W), .PER_W(PER_W), .HW_W(HW_W)
  ) i_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .run_en(run_en), .commit_stb(commit_stb),
    .sh_div(sh_div), .sh_per(sh_per), .sh_hw(sh_hw)
  );

  bl_pwm_core #(
    .DIV_W(DIV_W), .PER_W(PER_W), .HW_W(HW_W)
  ) i_core (
    .clk(clk), .rst_n(rst_n),
    .run_en(run_en), .commit_stb(commit_stb),
    .sh_div(sh_div), .sh_per(sh_per), .sh_hw(sh_hw),
    .pwm_out(pwm_out)
  );
endmodule

// File: tb/test_bl_pwm_ctrl.sv
module test_bl_pwm_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwm_out;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bl_pwm_ctrl i_bl_pwm_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out)
  );

  // behavioural reference model
  logic [31:0] m_word [4];
  int m_div, m_per, m_hw, m_pre, m_cnt;
  bit m_pend;

  function automatic int idx_of(input logic [7:0] a);
    case (a)
      8'h00: return 0;
      8'h08: return 1;
      8'h10: return 2;
      8'h14: return 3;
      default: return -1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_word[k]) m_word[k] = '0;
      m_div = 0; m_per = 0; m_hw = 0; m_pre = 0; m_cnt = 0; m_pend = 0;
    end else begin
      bit running, pulse, edge_end, take;
      int ix;
      running  = m_word[0][0];
      ix       = bus_sel ? idx_of(bus_addr) : -1;
      pulse    = bus_wr && ix == 1 && bus_wdata[0] && !m_word[1][0];
      edge_end = (m_pre == m_div) && (m_cnt == m_per);
      take     = (pulse || m_pend) && (!running || edge_end);
      if (!running) begin
        m_pre = 0; m_cnt = 0;
      end else if (m_pre == m_div) begin
        m_pre = 0;
        m_cnt = edge_end ? 0 : m_cnt + 1;
      end else m_pre++;
      if (take) begin
        m_div = int'(m_word[2][25:16]);
        m_per = int'(m_word[3][11:0]);
        m_hw  = int'(m_word[3][28:16]);
      end
      m_pend = (pulse || m_pend) && !take;
      if (bus_wr && ix >= 0) m_word[ix] = bus_wdata;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic exp_out;
      exp_out = m_word[0][0] && (m_cnt <= m_hw);
      check(pwm_out === exp_out, "R6 model pwm_out", 32'(pwm_out), 32'(exp_out));
      if (bus_sel && !bus_wr) begin
        logic [31:0] er;
        er = (idx_of(bus_addr) >= 0) ? m_word[idx_of(bus_addr)] : '0;
        check(bus_rdata === er, "R2 model rdata", bus_rdata, er);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); #1;
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #4;
    check(bus_rdata === exp, tag, bus_rdata, exp);
    @(negedge clk); #1;
    bus_sel = 0;
  endtask

  task automatic commit();
    wr(8'h08, 32'h0);
    wr(8'h08, 32'h1);
  endtask

  task automatic measure(output int hi, output int tot);
    @(negedge clk);
    while (pwm_out !== 1'b0) @(negedge clk);
    while (pwm_out !== 1'b1) @(negedge clk);
    hi = 0; tot = 0;
    while (pwm_out === 1'b1) begin hi++; tot++; @(negedge clk); end
    while (pwm_out === 1'b0) begin tot++; @(negedge clk); end
  endtask

  task automatic steady_high(input int n, input string tag);
    bit all_hi = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out !== 1'b1) all_hi = 0;
    end
    check(all_hi, tag, 32'(all_hi), 32'd1);
  endtask

  initial begin
    #(200000 * 20);
    check(0, "watchdog expired", 0, 1);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int hi, tot;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    // R1: reset state
    rd(8'h00, 32'h0, "R1 run word");
    rd(8'h08, 32'h0, "R1 commit word");
    rd(8'h10, 32'h0, "R1 prescale word");
    rd(8'h14, 32'h0, "R1 shape word");
    check(pwm_out === 1'b0, "R1 pwm_out", 32'(pwm_out), 0);

    // R4: run with zeroed active set; shadow writes must not alter output
    wr(8'h00, 32'h1);
    wr(8'h10, 32'hC002_00AB);               // D=2 plus foreign bits
    wr(8'h14, 32'hE003_F007);               // H=3, P=7 plus foreign bits
    rd(8'h10, 32'hC002_00AB, "R2 prescale readback");
    rd(8'h14, 32'hE003_F007, "R2 shape readback");
    steady_high(20, "R4 shadow ignored before commit");
    commit();
    measure(hi, tot);
    check(tot == 24, "R5 period 3x8", tot, 24);
    check(hi == 12, "R6 high 3x4", hi, 12);

    // R4: rewriting 1 while bit is set does not transfer
    wr(8'h14, 32'h0001_0003);               // H=1, P=3
    wr(8'h08, 32'h1);
    measure(hi, tot);
    check(tot == 24, "R4 no transfer on repeated 1", tot, 24);

    // R8: deferred commit while running
    measure(hi, tot);
    while (pwm_out !== 1'b1) @(negedge clk);
    repeat (14) @(negedge clk);
    commit();
    measure(hi, tot);
    check(tot == 12, "R8 deferred period", tot, 12);
    check(hi == 6, "R8 deferred high", hi, 6);

    // R3: unmapped addresses
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h04, 32'h0, "R3 unmapped 0x04");
    rd(8'h18, 32'h0, "R3 unmapped 0x18");
    rd(8'h14, 32'h0001_0003, "R3 shape untouched");
    rd(8'h0C, 32'h0, "R3 unmapped 0x0C");

    // R7: H above and equal to P
    wr(8'h10, 32'h0);
    wr(8'h14, 32'h0009_0005);
    commit();
    repeat (30) @(negedge clk);
    steady_high(30, "R7 H>P stays high");
    wr(8'h14, 32'h0005_0005);
    commit();
    repeat (10) @(negedge clk);
    steady_high(30, "R7 H=P stays high");

    // R9 and R8: stop, commit while stopped, restart fresh
    wr(8'h00, 32'hF0);
    rd(8'h00, 32'hF0, "R2 run word readback");
    repeat (3) @(negedge clk);
    check(pwm_out === 1'b0, "R9 low when stopped", 32'(pwm_out), 0);
    wr(8'h10, 32'h0001_0000);               // D=1
    wr(8'h14, 32'h0000_0004);               // H=0, P=4
    commit();
    @(negedge clk); #1;
    bus_sel = 1; bus_wr = 1; bus_addr = 8'h00; bus_wdata = 32'h1;
    @(negedge clk);
    check(pwm_out === 1'b1, "R9 fresh period high first", 32'(pwm_out), 1);
    #1 bus_sel = 0; bus_wr = 0;
    @(negedge clk);
    check(pwm_out === 1'b1, "R9 second high cycle", 32'(pwm_out), 1);
    @(negedge clk);
    check(pwm_out === 1'b0, "R9 low after 2 cycles", 32'(pwm_out), 0);
    measure(hi, tot);
    check(tot == 10, "R8 stopped commit period", tot, 10);
    check(hi == 2, "R6 stopped commit high", hi, 2);

    repeat (5) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule